// File: doc/BRIEF.md
# XOR-Recurrence Byte Stream Generator

This block produces an endless stream of bytes on a valid/ready output channel. The stream opens with a fixed four-byte seed. Every later byte is formed by XOR-ing three bytes that already appeared in the stream: the ones one, three and four places earlier. A consumer takes bytes at whatever pace it likes by driving ready, and the generator moves forward exactly one element on each accepted transfer.

Internally a four-entry window holds the element currently on the output and the three elements after it. When a transfer is accepted, the window shifts by one place. The newly exposed last entry is computed from three window taps. A synchronous reset reloads the seed and restarts the stream at element 0.

Top module: `xrs_byte_gen`

## Requirements
- R1: The first four bytes transferred after reset are 0x3F, 0xE2, 0x65 and 0xCA, in that order.
- R2: For every stream position n of 4 or more, the byte is element n-1 XOR element n-3 XOR element n-4. This makes the fifth and sixth bytes 0x17 and 0x90.
- R3: `out_valid` is low on every clock edge at which `rst_n` is sampled low. It goes high at the first edge at which `rst_n` is sampled high, and it stays high until the next reset.
- R4: The stream advances by exactly one element on each rising edge where `out_valid` and `out_ready` are both high, and at no other edge. With `out_ready` held high, one byte is transferred on every cycle.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` holds its value into the next cycle.
- R6: Asserting reset in the middle of the stream discards the position, so the next byte transferred is element 0 (0x3F), followed by the rest of the seed.
- R7: The stream has no end. Bytes beyond position 64 keep following the rule of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| out_valid | output | 1 | A stream byte is on `out_data` |
| out_ready | input | 1 | The consumer accepts the byte this cycle |
| out_data | output | 8 | Current stream byte |

## Verification
The bench builds the generator with its default 8-bit width and four-entry window. These are the only values in scope, so the real seed and the real tap distances are what it exercises. A software model of the recurrence supplies 104 expected bytes, and a scoreboard checks them under random ready stalls and then under a 40-cycle run with ready held high. That run reaches well past position 64 and confirms one transfer per cycle. A reset in the middle of the stream then checks that the sequence restarts at the seed.

// File: rtl/xrs_pkg.sv
// Package: shared constants and types for the XOR-recurrence byte stream
// generator. Assumes a fixed 8-bit element and a four-element window.
package xrs_pkg;
    parameter int XRS_W     = 8;
    parameter int XRS_DEPTH = 4;
    localparam int XRS_IDX_W = $clog2(XRS_DEPTH);

    typedef logic [XRS_W-1:0] xrs_elem_t;

    // Seed, element 0 first.
    localparam logic [XRS_DEPTH-1:0][XRS_W-1:0] XRS_SEED =
        {8'hCA, 8'h65, 8'hE2, 8'h3F};

    // Window slot k holds element (current + k). The next element is the
    // current element plus four; its sources are slots 0, 1 and 3.
    localparam logic [XRS_DEPTH-1:0] XRS_TAP_MASK = 4'b1011;
endpackage

// File: rtl/xrs_tap_xor.sv
// Module: xrs_tap_xor
// XOR-reduces the window slots selected by TAP_MASK into one element.
// Purely combinational; assumes at least one tap bit is set.
module xrs_tap_xor #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter logic [DEPTH-1:0] TAP_MASK = 4'b1011
) (
    input  logic [DEPTH-1:0][W-1:0] window,
    output logic [W-1:0]            next_elem
);
    logic [DEPTH:0][W-1:0] partial;

    assign partial[0] = '0;

    // One stage per slot: fold the slot in when its tap bit is set.
    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        if (TAP_MASK[k]) begin : g_on
            assign partial[k+1] = partial[k] ^ window[k];
        end else begin : g_off
            assign partial[k+1] = partial[k];
        end
    end

    assign next_elem = partial[DEPTH];
endmodule

// File: rtl/xrs_window.sv
// Module: xrs_window
// Holds the current element and the DEPTH-1 elements after it. On step it
// shifts toward slot 0 and loads next_elem into the last slot. A synchronous
// active-low reset reloads SEED. Assumes next_elem is derived from window.
module xrs_window #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter logic [DEPTH-1:0][W-1:0] SEED = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic [W-1:0]            next_elem,
    output logic [DEPTH-1:0][W-1:0] window
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        if (k == DEPTH - 1) begin : g_last
            // Last slot: reload seed on reset, take the new element on step.
            always_ff @(posedge clk) begin
                if (!rst_n)    window[k] <= SEED[k];
                else if (step) window[k] <= next_elem;
            end
        end else begin : g_mid
            // Inner slot: reload seed on reset, take the next slot on step.
            always_ff @(posedge clk) begin
                if (!rst_n)    window[k] <= SEED[k];
                else if (step) window[k] <= window[k+1];
            end
        end
    end

    // R5: with no step, slot 0 must not move.
    a_r5_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(window[0]));
    // R4: on a step, slot 0 takes the value that slot 1 had.
    a_r4_shift_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> window[0] == $past(window[1]));
endmodule

// File: rtl/xrs_byte_gen.sv
// Module: xrs_byte_gen (top)
// Endless byte stream: a four-byte seed, then each byte is the XOR of the
// bytes one, three and four positions back. The output uses valid/ready and
// advances one element per accepted transfer. Synchronous active-low reset.
// Assumes the consumer follows valid/ready; valid never drops outside reset.
module xrs_byte_gen
    import xrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [XRS_W-1:0] out_data
);
    logic [XRS_DEPTH-1:0][XRS_W-1:0] window;
    logic [XRS_W-1:0]                next_elem;
    logic                            valid_q;
    logic                            fire;

    assign fire      = valid_q && out_ready;
    assign out_valid = valid_q;
    assign out_data  = window[0];

    // Output valid: cleared in reset, set at the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= 1'b1;
    end

    xrs_window #(
        .W(XRS_W), .DEPTH(XRS_DEPTH), .SEED(XRS_SEED)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .step(fire),
        .next_elem(next_elem), .window(window)
    );

    xrs_tap_xor #(
        .W(XRS_W), .DEPTH(XRS_DEPTH), .TAP_MASK(XRS_TAP_MASK)
    ) u_taps (
        .window(window), .next_elem(next_elem)
    );

    // ---------------- assertion support: history of emitted bytes ----------
    logic [XRS_DEPTH-1:0][XRS_W-1:0] seen;
    logic [XRS_IDX_W:0]              seen_cnt;

    // Record each transferred byte, newest in slot 0; count up to DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= '0;
            seen_cnt <= '0;
        end else if (fire) begin
            seen <= {seen[XRS_DEPTH-2:0], out_data};
            if (seen_cnt != (XRS_IDX_W+1)'(XRS_DEPTH)) seen_cnt <= seen_cnt + 1'b1;
        end
    end

    // R1: the first byte after reset is the seed head.
    a_r1_seed_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> out_data == 8'h3F);
    // R1: the second to fourth bytes follow the seed.
    a_r1_seed_rest: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && seen_cnt < 3'd4 && seen_cnt > 3'd0 |->
            out_data == XRS_SEED[seen_cnt[1:0]]);
    // R2: once four bytes are known, the current byte obeys the recurrence.
    a_r2_recurrence: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && seen_cnt == 3'd4 |-> out_data == (seen[0] ^ seen[2] ^ seen[3]));
    // R3: once valid, stays valid until reset.
    a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);
    // R5: a stalled byte holds.
    a_r5_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !out_ready |=> $stable(out_data));
endmodule

// File: tb/tb_xrs_byte_gen.sv
// Scoreboard bench: a driver task pushes model-computed expected indices into
// a queue; a monitor pops and compares at each accepted transfer.
module tb_xrs_byte_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    int got    = 0;
    bit restart_phase = 1'b0;
    logic [7:0] model [0:127];
    int exp_q [$];

    always #2.5 clk = ~clk;

    xrs_byte_gen dut (
        .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: push the expected stream positions first..first+n-1.
    task automatic push_expected(input int first, input int n);
        for (int i = first; i < first + n; i++) exp_q.push_back(i);
    endtask

    // Monitor: sample between edges; compare transfers and stalls.
    bit         prev_stall = 1'b0;
    bit         prev_valid = 1'b0;
    logic [7:0] prev_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) check(out_data == prev_data, "R5 stall hold", out_data, prev_data);
            if (prev_valid) check(out_valid == 1'b1, "R3 valid stays high", out_valid, 1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 transfer with nothing expected", out_data, 0);
                end else begin
                    int idx;
                    idx = exp_q.pop_front();
                    if (restart_phase && idx == 0)
                        check(out_data == model[0], "R6 restart at element 0", out_data, model[0]);
                    else if (idx < 4)
                        check(out_data == model[idx], "R1 seed byte", out_data, model[idx]);
                    else if (idx >= 64)
                        check(out_data == model[idx], "R7 stream beyond 64", out_data, model[idx]);
                    else
                        check(out_data == model[idx], "R2 recurrence byte", out_data, model[idx]);
                end
                got++;
            end
            prev_stall = out_valid && !out_ready;
            prev_valid = out_valid;
            prev_data  = out_data;
        end else begin
            prev_stall = 1'b0;
            prev_valid = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        #400000;
        check(1'b0, "watchdog expired", got, 120);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model[0] = 8'h3F; model[1] = 8'hE2; model[2] = 8'h65; model[3] = 8'hCA;
        for (int n = 4; n < 128; n++) model[n] = model[n-1] ^ model[n-3] ^ model[n-4];

        rst_n = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 valid low in reset", out_valid, 0);
        check(model[4] == 8'h17 && model[5] == 8'h90, "R2 model 5th/6th", model[5], 8'h90);

        // Phase A: 64 bytes under random stalls.
        push_expected(0, 64);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R3 valid before first edge out of reset", out_valid, 0);
        @(posedge clk); #1;
        check(out_valid == 1'b1, "R3 valid after first edge out of reset", out_valid, 1);
        forever begin
            if (got >= 64) break;
            out_ready = ($urandom_range(0, 9) < 6);
            @(posedge clk); #1;
        end

        // Phase B: ready held high, one transfer per cycle, past position 64.
        push_expected(64, 40);
        out_ready = 1'b1;
        repeat (40) @(posedge clk);
        #1 out_ready = 1'b0;
        @(negedge clk);
        check(got == 104, "R4 one transfer per cycle", got, 104);
        check(exp_q.size() == 0, "R4 all expected consumed", exp_q.size(), 0);
        @(negedge clk);
        check(got == 104, "R4 no transfer while ready low", got, 104);

        // Phase C: mid-stream reset restarts the seed.
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 valid low in mid-stream reset", out_valid, 0);
        restart_phase = 1'b1;
        push_expected(0, 16);
        @(posedge clk); #1 rst_n = 1'b1;
        forever begin
            if (got >= 120) break;
            out_ready = ($urandom_range(0, 9) < 5);
            @(posedge clk); #1;
        end
        out_ready = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0 && got == 120, "R6 restart stream complete", got, 120);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule